// File: doc/BRIEF.md
# Staged hot-plug connection sequencer

This block drives the enable lines of a bank of switched connector signals, so that a host can imitate a device being plugged in or pulled out of a connector whose pins have different lengths. Every signal is tied to one of a few shared timing sources. Each source holds a delay in millisecond ticks. When an insertion is commanded, each signal's enable rises once the tick count since the command reaches the delay of its source. When a removal is commanded, the sources drop in reverse order: the source with the largest delay goes first, and everything is off once that largest delay has elapsed.

Delays, signal-to-source assignments and a lane width select live in a small register bank written through a simple write port. They are copied into shadow storage when a command is accepted, so a sweep of timings can be set up while a sequence is still running without disturbing it. Source number 0 means "never connect", which lets a test script disable lanes or park signals. A spare fourth source exists for signals under test, and a restore command puts the whole register bank back to its power-on values.

Top module: `hotplug_seq`

## Requirements
- R1: After reset all connect enables are low and busy is low.
- R2: Register map: address s-1 holds the 16-bit delay of source s (s = 1..4). Address 0x20 holds the width code in bits 1:0. Address 0x40+i holds the source number of signal i in bits 2:0. Power-on values: delay of source s is 25*(s-1) ticks; signals 0..15 are lanes on source 2; signals from 16 upward alternate between source 1 (even offset from 16) and source 3 (odd offset); width code is 2.
- R3: An insertion command accepted while idle latches the configuration; after k ticks a source with delay d is connected when k >= d, and busy stays high while k is below the largest source delay, dropping once k reaches it.
- R4: A removal command accepted while idle turns off a source with delay d once k >= maxd - d ticks have passed, maxd being the largest source delay; busy behaves as in R3.
- R5: A signal whose source number is 0, or is above 4, never has its enable high.
- R6: Width code 0 allows lanes 0..3, code 1 lanes 0..7, codes 2 and 3 lanes 0..15; a lane outside the allowed range never has its enable high. Signals 16 and up are not affected.
- R7: Insertion and removal commands that arrive while busy is high are ignored; the running sequence continues unchanged.
- R8: Register writes made while a sequence runs take no effect on that sequence and apply from the next accepted command.
- R9: The restore command returns every delay, assignment and the width code to the R2 power-on values; the change shows from the next accepted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register address |
| wr_data | input | 16 | Register write data |
| cmd_up | input | 1 | Insertion command strobe |
| cmd_down | input | 1 | Removal command strobe |
| cmd_default | input | 1 | Restore power-on configuration |
| tick_ms | input | 1 | One-cycle millisecond tick |
| conn_en | output | 20 | Connect enable per signal |
| busy | output | 1 | High while a sequence runs |

## Verification
The assertions assume that command strobes and ticks are single-cycle pulses and that the tick count never exceeds the largest latched delay before busy drops, which the counter design guarantees; they also assume the bench never issues a command in the same cycle as a tick. The stimulus keeps ticks at least two cycles apart, drives every strobe for exactly one cycle on the falling clock edge, and issues commands only at points where the model knows whether busy is high, including deliberate commands during a running sequence to exercise the ignore rule.

// File: rtl/hps_pkg.sv
package hps_pkg;
  localparam int ADDR_W_DEF = 8;
  localparam int DLY_W_DEF  = 16;
  localparam logic [7:0] WIDTH_ADDR = 8'h20;
  localparam logic [7:0] ASG_BASE   = 8'h40;

  // power-on delay of source s, in ticks
  function automatic int dflt_delay(int s);
    return 25 * (s - 1);
  endfunction

  // power-on source number of signal i
  function automatic int dflt_src(int i, int nlane);
    if (i < nlane) return 2;
    return (((i - nlane) % 2) == 0) ? 1 : 3;
  endfunction

  // number of lanes allowed by a width code
  function automatic int lane_limit(logic [1:0] code, int nlane);
    int lim;
    lim = (code == 2'd0) ? 4 : (code == 2'd1) ? 8 : 16;
    return (lim < nlane) ? lim : nlane;
  endfunction

  // tick count at which a source of delay d drops during removal
  function automatic logic [31:0] drop_point(logic [31:0] maxd, logic [31:0] d);
    return maxd - d;
  endfunction
endpackage

// File: rtl/hps_cfg_regs.sv
module hps_cfg_regs #(
  parameter int NUM_SIG  = 20,
  parameter int NUM_LANE = 16,
  parameter int NUM_SRC  = 4,
  parameter int DLY_W    = 16,
  parameter int ADDR_W   = 8,
  parameter int SRC_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DLY_W-1:0]  wr_data,
  input  logic              cmd_default,
  output logic [DLY_W-1:0]  dly_live [1:NUM_SRC],
  output logic [SRC_W-1:0]  asg_live [NUM_SIG],
  output logic [1:0]        wid_live
);
  import hps_pkg::*;

  for (genvar s = 1; s <= NUM_SRC; s++) begin : g_dly
    localparam logic [DLY_W-1:0] INIT = DLY_W'(dflt_delay(s));
    logic hit;
    assign hit = wr_en && (wr_addr == ADDR_W'(s - 1));
    always_ff @(posedge clk) begin
      if (!rst_n || cmd_default) dly_live[s] <= INIT;
      else if (hit)              dly_live[s] <= wr_data;
    end
  end

  for (genvar i = 0; i < NUM_SIG; i++) begin : g_asg
    localparam logic [SRC_W-1:0] INIT = SRC_W'(dflt_src(i, NUM_LANE));
    logic hit;
    assign hit = wr_en && (wr_addr == ADDR_W'(ASG_BASE) + ADDR_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n || cmd_default) asg_live[i] <= INIT;
      else if (hit)              asg_live[i] <= wr_data[SRC_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || cmd_default)                       wid_live <= 2'd2;
    else if (wr_en && wr_addr == ADDR_W'(WIDTH_ADDR)) wid_live <= wr_data[1:0];
  end
endmodule

// File: rtl/hps_timer.sv
module hps_timer #(
  parameter int NUM_SIG = 20,
  parameter int NUM_SRC = 4,
  parameter int DLY_W   = 16,
  parameter int SRC_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_up,
  input  logic             cmd_down,
  input  logic             tick_ms,
  input  logic [DLY_W-1:0] dly_live [1:NUM_SRC],
  input  logic [SRC_W-1:0] asg_live [NUM_SIG],
  input  logic [1:0]       wid_live,
  output logic [DLY_W-1:0] dly_sh [1:NUM_SRC],
  output logic [SRC_W-1:0] asg_sh [NUM_SIG],
  output logic [1:0]       wid_sh,
  output logic [DLY_W-1:0] cnt,
  output logic [DLY_W-1:0] maxd,
  output logic             busy,
  output logic             dir_up,
  output logic             cmd_accept,
  output logic             seq_done
);
  import hps_pkg::*;

  assign cmd_accept = (cmd_up || cmd_down) && !busy;
  assign seq_done   = busy && (cnt >= maxd);

  always_comb begin
    maxd = '0;
    for (int s = 1; s <= NUM_SRC; s++)
      if (dly_sh[s] > maxd) maxd = dly_sh[s];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      dir_up <= 1'b0;
      cnt    <= '0;
    end else if (cmd_accept) begin
      busy   <= 1'b1;
      dir_up <= cmd_up;
      cnt    <= '0;
    end else if (seq_done) begin
      busy   <= 1'b0;
    end else if (busy && tick_ms) begin
      cnt    <= cnt + 1'b1;
    end
  end

  for (genvar s = 1; s <= NUM_SRC; s++) begin : g_shd
    always_ff @(posedge clk) begin
      if (!rst_n)          dly_sh[s] <= DLY_W'(dflt_delay(s));
      else if (cmd_accept) dly_sh[s] <= dly_live[s];
    end
  end

  for (genvar i = 0; i < NUM_SIG; i++) begin : g_sha
    always_ff @(posedge clk) begin
      if (!rst_n)          asg_sh[i] <= '0;
      else if (cmd_accept) asg_sh[i] <= asg_live[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          wid_sh <= 2'd2;
    else if (cmd_accept) wid_sh <= wid_live;
  end
endmodule

// File: rtl/hps_src_state.sv
module hps_src_state #(
  parameter int NUM_SRC = 4,
  parameter int DLY_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic             dir_up,
  input  logic [DLY_W-1:0] cnt,
  input  logic [DLY_W-1:0] maxd,
  input  logic [DLY_W-1:0] dly_sh [1:NUM_SRC],
  output logic [NUM_SRC:0] src_on
);
  import hps_pkg::*;

  assign src_on[0] = 1'b0;

  for (genvar s = 1; s <= NUM_SRC; s++) begin : g_src
    logic up_hit, dn_hit, on_q;
    logic [DLY_W-1:0] dpt;
    assign dpt    = DLY_W'(drop_point(32'(maxd), 32'(dly_sh[s])));
    assign up_hit = busy && dir_up && (cnt >= dly_sh[s]);
    assign dn_hit = busy && !dir_up && (cnt >= dpt);
    always_ff @(posedge clk) begin
      if (!rst_n)      on_q <= 1'b0;
      else if (up_hit) on_q <= 1'b1;
      else if (dn_hit) on_q <= 1'b0;
    end
    assign src_on[s] = on_q;
  end
endmodule

// File: rtl/hotplug_seq.sv
module hotplug_seq #(
  parameter int NUM_SIG  = 20,
  parameter int NUM_LANE = 16,
  parameter int NUM_SRC  = 4,
  parameter int DLY_W    = hps_pkg::DLY_W_DEF,
  parameter int ADDR_W   = hps_pkg::ADDR_W_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DLY_W-1:0]   wr_data,
  input  logic               cmd_up,
  input  logic               cmd_down,
  input  logic               cmd_default,
  input  logic               tick_ms,
  output logic [NUM_SIG-1:0] conn_en,
  output logic               busy
);
  import hps_pkg::*;

  localparam int SRC_W   = $clog2(NUM_SRC + 1);
  localparam int SRC_PAD = 2 ** SRC_W;

  logic [DLY_W-1:0] dly_live [1:NUM_SRC];
  logic [SRC_W-1:0] asg_live [NUM_SIG];
  logic [1:0]       wid_live;
  logic [DLY_W-1:0] dly_sh   [1:NUM_SRC];
  logic [SRC_W-1:0] asg_sh   [NUM_SIG];
  logic [1:0]       wid_sh;
  logic [DLY_W-1:0] cnt, maxd;
  logic             dir_up, cmd_accept, seq_done;
  logic [NUM_SRC:0] src_on;
  logic [SRC_PAD-1:0] on_pad;

  hps_cfg_regs #(.NUM_SIG(NUM_SIG), .NUM_LANE(NUM_LANE), .NUM_SRC(NUM_SRC),
                 .DLY_W(DLY_W), .ADDR_W(ADDR_W), .SRC_W(SRC_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cmd_default(cmd_default), .dly_live(dly_live), .asg_live(asg_live),
    .wid_live(wid_live));

  hps_timer #(.NUM_SIG(NUM_SIG), .NUM_SRC(NUM_SRC), .DLY_W(DLY_W),
              .SRC_W(SRC_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .cmd_up(cmd_up), .cmd_down(cmd_down),
    .tick_ms(tick_ms), .dly_live(dly_live), .asg_live(asg_live),
    .wid_live(wid_live), .dly_sh(dly_sh), .asg_sh(asg_sh), .wid_sh(wid_sh),
    .cnt(cnt), .maxd(maxd), .busy(busy), .dir_up(dir_up),
    .cmd_accept(cmd_accept), .seq_done(seq_done));

  hps_src_state #(.NUM_SRC(NUM_SRC), .DLY_W(DLY_W)) u_src (
    .clk(clk), .rst_n(rst_n), .busy(busy), .dir_up(dir_up), .cnt(cnt),
    .maxd(maxd), .dly_sh(dly_sh), .src_on(src_on));

  // source numbers above NUM_SRC land on zero padding, like source 0
  assign on_pad = SRC_PAD'(src_on);

  for (genvar i = 0; i < NUM_SIG; i++) begin : g_out
    logic lane_ok;
    if (i < NUM_LANE) begin : g_lane
      assign lane_ok = (i < lane_limit(wid_sh, NUM_LANE));
    end else begin : g_side
      assign lane_ok = 1'b1;
    end
    assign conn_en[i] = on_pad[asg_sh[i]] && lane_ok;
  end
endmodule

// File: rtl/hps_checker.sv
module hps_checker #(
  parameter int NUM_SIG = 20,
  parameter int NUM_SRC = 4,
  parameter int DLY_W   = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busy,
  input logic               dir_up,
  input logic               cmd_accept,
  input logic               seq_done,
  input logic [DLY_W-1:0]   cnt,
  input logic [DLY_W-1:0]   maxd,
  input logic [NUM_SRC:0]   src_on,
  input logic [NUM_SIG-1:0] conn_en
);
  assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !busy);

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt <= maxd));

  assert_up_no_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dir_up) |=> ((src_on & $past(src_on)) == $past(src_on)));

  assert_down_no_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !dir_up) |=> ((src_on | $past(src_on)) == $past(src_on)));

  assert_src0_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !src_on[0]);

  assert_no_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !seq_done) |=> (busy && cnt >= $past(cnt)));

  assert_idle_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cmd_accept) |=> $stable(conn_en));
endmodule

bind hotplug_seq hps_checker #(.NUM_SIG(NUM_SIG), .NUM_SRC(NUM_SRC), .DLY_W(DLY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .dir_up(dir_up), .cmd_accept(cmd_accept),
  .seq_done(seq_done), .cnt(cnt), .maxd(maxd), .src_on(src_on), .conn_en(conn_en));

// File: tb/hotplug_seq_tb.sv
module hotplug_seq_tb;
  localparam int NS = 20;
  localparam int NL = 16;
  localparam int NSRC = 4;

  logic clk = 0, rst_n = 0, wr_en = 0, cmd_up = 0, cmd_down = 0, cmd_default = 0, tick_ms = 0;
  logic [7:0] wr_addr = 0;
  logic [15:0] wr_data = 0;
  logic [NS-1:0] conn_en;
  logic busy;
  int total = 0, bad = 0;
  bit finished = 0;

  int m_dly [1:NSRC], s_dly [1:NSRC];
  int m_asg [NS], s_asg [NS];
  int m_wid, s_wid;
  bit on [1:NSRC];

  always #10 clk = ~clk;

  hotplug_seq u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cmd_up(cmd_up), .cmd_down(cmd_down), .cmd_default(cmd_default),
    .tick_ms(tick_ms), .conn_en(conn_en), .busy(busy));

  task automatic model_default();
    for (int s = 1; s <= NSRC; s++) m_dly[s] = 25 * (s - 1);
    for (int i = 0; i < NS; i++) m_asg[i] = (i < NL) ? 2 : (((i - NL) % 2 == 0) ? 1 : 3);
    m_wid = 2;
  endtask

  function automatic logic [NS-1:0] exp_conn();
    logic [NS-1:0] v;
    int lim;
    lim = (s_wid == 0) ? 4 : (s_wid == 1) ? 8 : 16;
    for (int i = 0; i < NS; i++) begin
      v[i] = (s_asg[i] >= 1 && s_asg[i] <= NSRC) && (i >= NL || i < lim);
      if (v[i]) v[i] = on[s_asg[i]];
    end
    return v;
  endfunction

  function automatic int s_max();
    int m = 0;
    for (int s = 1; s <= NSRC; s++) if (s_dly[s] > m) m = s_dly[s];
    return m;
  endfunction

  task automatic check(string tag, logic [NS:0] act, logic [NS:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk) sig = 1;
    @(negedge clk) sig = 0;
    @(negedge clk);
  endtask

  task automatic wr(int addr, int data);
    @(negedge clk) begin wr_en = 1; wr_addr = 8'(addr); wr_data = 16'(data); end
    @(negedge clk) wr_en = 0;
    if (addr < NSRC) m_dly[addr + 1] = data;
    else if (addr == 'h20) m_wid = data & 3;
    else m_asg[addr - 'h40] = data & 7;
  endtask

  // inj: 0 none, 1 opposite command at k==2, 2 write source 3 delay=2 at k==3
  task automatic sweep(bit up, string tag, int inj);
    int mx;
    s_dly = m_dly; s_asg = m_asg; s_wid = m_wid;
    mx = s_max();
    if (up) pulse(cmd_up); else pulse(cmd_down);
    for (int k = 0; k <= mx; k++) begin
      if (k > 0) pulse(tick_ms);
      for (int s = 1; s <= NSRC; s++)
        if (up) on[s] = on[s] || (k >= s_dly[s]);
        else    on[s] = on[s] && !(k >= mx - s_dly[s]);
      check(tag, {busy, conn_en}, {(k < mx) ? 1'b1 : 1'b0, exp_conn()});
      if (inj == 1 && k == 2) begin
        if (up) pulse(cmd_down); else pulse(cmd_up);
        check({tag, " R7 ignore"}, {busy, conn_en}, {1'b1, exp_conn()});
      end
      if (inj == 2 && k == 3) begin
        wr(2, 2);
        @(negedge clk);
        check({tag, " R8 mid write"}, {busy, conn_en}, {(k < mx) ? 1'b1 : 1'b0, exp_conn()});
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    model_default();
    for (int s = 1; s <= NSRC; s++) on[s] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset", {busy, conn_en}, '0);
    // power-on configuration, insertion then removal
    sweep(1, "R2 R3 default up", 0);
    sweep(0, "R2 R4 default down", 0);
    // custom delays, source 0 and out-of-range sources, narrow width
    wr(0, 3); wr(1, 0); wr(2, 7); wr(3, 5);
    for (int i = 0; i < NS; i++) wr('h40 + i, i % 5);
    wr('h40 + 19, 6);
    wr('h20, 0);
    sweep(1, "R3 R5 R6 custom up w4", 1);
    @(negedge clk);
    check("R8 idle stable", {busy, conn_en}, {1'b0, exp_conn()});
    sweep(0, "R4 R8 custom down", 2);
    sweep(1, "R8 new delay up", 0);
    wr('h20, 1);
    sweep(0, "R4 R7 down", 1);
    sweep(1, "R6 width8 up", 0);
    wr('h20, 3);
    sweep(0, "R6 down", 0);
    sweep(1, "R6 width16 up", 0);
    sweep(0, "R4 down", 0);
    // restore command
    pulse(cmd_default);
    model_default();
    check("R9 restore idle", {busy, conn_en}, {1'b0, exp_conn()});
    sweep(1, "R9 restored up", 0);
    sweep(0, "R9 restored down", 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule